// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block collects 28 external interrupt pins and turns them into four summary interrupt requests for an upstream interrupt controller. Every pin is brought into the clock domain through a two-flop synchroniser. Each pin is then checked against a trigger mode: low level, high level, falling edge, rising edge or both edges. The mode is set per pair of adjacent pins. A detected event sets a sticky pending bit for that line. Software clears a pending bit by writing a one to it.

Each line has a mask bit. The pending bits that are not masked are ORed into four registered group outputs. The groups are uneven: lines 0–3, 4–11, 12–19 and 20–27. Software reads the pending and mask registers to find out which line raised a group request.

Configuration uses a small register bus. It has a single-cycle write strobe and a two-bit word address that selects one of four 32-bit registers. Read data is combinational.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Word address 0 holds the trigger fields for lines 0–15, address 1 holds those for lines 16–27, address 2 is the mask, and address 3 is the pending register. A write takes effect at the clock edge where `wr_en` is high. `rdata` shows the register selected by `addr` in the same cycle.
- R2: The trigger field for line i is 3 bits wide and starts at bit ((i mod 16)/2)*4. Lines 2k and 2k+1 share that field. Bit 3 of each nibble is not stored and reads 0. Bits 31:24 of address 1 would belong to lines above 27, so they are ignored and read 0.
- R3: After reset the mask reads 0x0FFFFFFF, pending reads 0, both trigger registers read 0, and `grp_irq` is 0.
- R4: The trigger codes are: 000 low level, 001 high level, 01x falling edge, 10x rising edge, 11x both edges. An edge mode sets the pending bit on the selected transition only.
- R5: A mask bit of 1 blocks its line from `grp_irq`, but the line still records pending. Mask bits 31:28 read 0.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Without a clear, a set pending bit stays set.
- R7: In a level mode the pending bit is set again on every cycle the level is present, so a clear has no effect until the level goes away. Once the level has gone away the bit stays set until it is cleared.
- R8: If a clear and an event hit the same line in the same cycle, the pending bit ends up set.
- R9: `grp_irq[0..3]` are registered ORs of pending AND NOT mask over lines 0–3, 4–11, 12–19 and 20–27. A group output follows a change in pending or mask one clock later.
- R10: A pin change made between two clock edges shows in the pending register after the third rising edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 28 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| grp_irq | output | 4 | Registered group interrupt requests |

## Verification
If the synchroniser or the previous-sample register holds a wrong value, a pending bit sets one cycle early or late, sets on the wrong edge, or does not set at all. The bench sees this in the pending read three edges after a pin change. If a pending or mask bit is corrupted, the matching group output shows it one clock later, and a read of either register shows it at once. If a configuration field is misplaced, the readback at addresses 0 and 1 is wrong at once, and a line then ignores the edge it should catch.

// File: rtl/eic_pkg.sv
package eic_pkg;

  localparam int FIELD_W = 3;
  localparam int NIB_W   = 4;
  localparam int PAIRS_PER_REG = 8;

  localparam logic [1:0] A_CFG_LO = 2'd0;
  localparam logic [1:0] A_CFG_HI = 2'd1;
  localparam logic [1:0] A_MASK   = 2'd2;
  localparam logic [1:0] A_PEND   = 2'd3;

  localparam int GRP_FIRST [4] = '{0, 4, 12, 20};
  localparam int GRP_LAST  [4] = '{3, 11, 19, 27};

  // Event for one line from its mode code, current and previous sample
  function automatic logic line_event(logic [2:0] mode, logic cur, logic prv);
    logic ev;
    case (mode[2:1])
      2'b00:   ev = mode[0] ? cur : ~cur;
      2'b01:   ev = prv & ~cur;
      2'b10:   ev = ~prv & cur;
      default: ev = prv ^ cur;
    endcase
    return ev;
  endfunction

  // Bit vector with ones over the lines of one group
  function automatic logic [31:0] grp_sel(int g);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 32; i++)
      if (i >= GRP_FIRST[g] && i <= GRP_LAST[g]) v[i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import eic_pkg::*;
#(
  parameter int N = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         sync_i,
  input  logic [N*FIELD_W-1:0] mode_i,
  output logic [N-1:0]         evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign evt_o[i] = line_event(mode_i[i*FIELD_W +: FIELD_W], sync_i[i], prev_q[i]);
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 28,
  parameter int DATA_W    = 32,
  parameter int GROUPS    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [GROUPS-1:0]    grp_irq
);
  localparam int PAIRS = (NUM_LINES + 1) / 2;

  logic [FIELD_W-1:0]           cfg_q [PAIRS];
  logic [NUM_LINES-1:0]         mask_q;
  logic [NUM_LINES-1:0]         pend_q;
  logic [NUM_LINES-1:0]         pin_s;
  logic [NUM_LINES-1:0]         evt;
  logic [NUM_LINES-1:0]         clr;
  logic [NUM_LINES-1:0]         active;
  logic [NUM_LINES*FIELD_W-1:0] mode_flat;
  logic                         unused_wbits;

  assign unused_wbits = ^wdata;

  eic_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(pin_s)
  );

  eic_detect #(.N(NUM_LINES)) u_det (
    .clk(clk), .rst(rst), .sync_i(pin_s), .mode_i(mode_flat), .evt_o(evt)
  );

  // Trigger fields, one per pair of lines
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int REG_IDX = p / PAIRS_PER_REG;
    localparam int SHIFT   = (p % PAIRS_PER_REG) * NIB_W;

    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[p] <= '0;
      else if (wr_en && addr == 2'(REG_IDX))
        cfg_q[p] <= wdata[SHIFT +: FIELD_W];
    end

    assign mode_flat[2*p*FIELD_W +: FIELD_W] = cfg_q[p];
    if (2*p + 1 < NUM_LINES) begin : g_odd
      assign mode_flat[(2*p+1)*FIELD_W +: FIELD_W] = cfg_q[p];
    end
  end

  // Mask and pending registers
  assign clr = (wr_en && addr == A_PEND) ? wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_en && addr == A_MASK) mask_q <= wdata[NUM_LINES-1:0];
      pend_q <= (pend_q & ~clr) | evt;
    end
  end

  // Group summary outputs
  assign active = pend_q & ~mask_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [31:0] SEL = grp_sel(g);
    always_ff @(posedge clk) begin
      if (rst) grp_irq[g] <= 1'b0;
      else     grp_irq[g] <= |(active & SEL[NUM_LINES-1:0]);
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    for (int p = 0; p < PAIRS; p++)
      if (addr == 2'(p / PAIRS_PER_REG))
        rdata[(p % PAIRS_PER_REG)*NIB_W +: FIELD_W] = cfg_q[p];
    if (addr == A_MASK) rdata[NUM_LINES-1:0] = mask_q;
    if (addr == A_PEND) rdata[NUM_LINES-1:0] = pend_q;
  end
endmodule

// File: rtl/eic_chk.sv
module eic_chk
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 28,
  parameter int DATA_W    = 32,
  parameter int GROUPS    = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic [1:0]                   addr,
  input logic [DATA_W-1:0]            wdata,
  input logic [DATA_W-1:0]            rdata,
  input logic [NUM_LINES-1:0]         pend,
  input logic [NUM_LINES-1:0]         mask,
  input logic [NUM_LINES-1:0]         sync_in,
  input logic [NUM_LINES*FIELD_W-1:0] mode_flat,
  input logic [GROUPS-1:0]            grp_irq
);
  // R2: lines above 27 do not exist, so their field bits read zero
  always_comb begin
    if (!rst && addr == A_CFG_HI)
      p_rsvd_zero_r2: assert (rdata[DATA_W-1:24] == '0);
  end

  // R6: without a clear write no pending bit drops
  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_PEND) |=> ((pend & $past(pend)) == $past(pend)));

  // R5: everything masked keeps all group outputs quiet
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> (grp_irq == '0));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    // R7: a present high level keeps pending set
    p_level_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (mode_flat[i*FIELD_W +: FIELD_W] == 3'b001 && sync_in[i]) |=> pend[i]);
    // R8: clear and event together leave the bit set
    p_clear_race_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_PEND && wdata[i] &&
       mode_flat[i*FIELD_W +: FIELD_W] == 3'b000 && !sync_in[i]) |=> pend[i]);
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [31:0] SEL = grp_sel(g);
    // R9: group output follows the unmasked pending lines one cycle later
    p_grp_follow_r9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (grp_irq[g] == $past(|(pend & ~mask & SEL[NUM_LINES-1:0]))));
  end
endmodule

bind ext_irq_ctrl eic_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .pend(pend_q), .mask(mask_q), .sync_in(pin_s), .mode_flat(mode_flat), .grp_irq(grp_irq)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [27:0] pins;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 register read, 1 group outputs
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .grp_irq(grp_irq)
  );

  // Driver side: queue an expectation for the current cycle
  task automatic chk_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_grp(input logic [3:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = 1; it.exp = {28'd0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pins[idx] = v;
  endtask

  // Monitor: pops expectations and compares between edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = (it.kind == 0) ? rdata : {28'd0, grp_irq};
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pins = 28'h0FFFFFFF;
    pins[6] = 1'b0;
    pins[7] = 1'b0;

    // R3 reset state
    chk_reg(2'd2, 32'h0FFFFFFF, "R3 mask reset");
    chk_reg(2'd3, 32'h0, "R3 pending reset");
    chk_reg(2'd0, 32'h0, "R3 cfg lo reset");
    chk_reg(2'd1, 32'h0, "R3 cfg hi reset");
    chk_grp(4'h0, "R3 grp reset");
    @(negedge clk);
    rst = 1'b0;
    idle(4);

    // R2 field layout and ignored upper fields
    wr(2'd0, 32'hFFFFFFFF);
    chk_reg(2'd0, 32'h77777777, "R2 lo nibble top bits");
    wr(2'd1, 32'hFFFFFFFF);
    chk_reg(2'd1, 32'h00777777, "R2 hi lines above 27");

    // R1 modes: pair0 rise, pair1 fall, pair2 both, pair3 high; hi pair0 both, pair5 rise
    wr(2'd0, 32'h00001624);
    wr(2'd1, 32'h00400006);
    chk_reg(2'd0, 32'h00001624, "R1 cfg lo");
    chk_reg(2'd1, 32'h00400006, "R1 cfg hi");

    wr(2'd3, 32'hFFFFFFFF);
    chk_reg(2'd3, 32'h0, "R6 clear all");
    chk_grp(4'h0, "R5 all masked");
    wr(2'd2, 32'hFFFFFFFF);
    chk_reg(2'd2, 32'h0FFFFFFF, "R5 mask upper bits");
    wr(2'd2, 32'h0);
    chk_reg(2'd2, 32'h0, "R1 mask write");

    // R4 rising line 0: falling transition ignored
    set_pin(0, 1'b0);
    idle(2);
    chk_reg(2'd3, 32'h0, "R4 rise ignores fall");
    idle(1);
    set_pin(0, 1'b1);
    idle(1);
    chk_reg(2'd3, 32'h0, "R10 not before third edge");
    chk_reg(2'd3, 32'h1, "R10 rise at third edge");
    chk_grp(4'h1, "R9 group 0");
    wr(2'd3, 32'h0);
    chk_reg(2'd3, 32'h1, "R6 write zero no effect");
    wr(2'd3, 32'h1);
    chk_reg(2'd3, 32'h0, "R6 write one clears");
    chk_grp(4'h0, "R9 group 0 drops");

    // R4 falling line 2
    set_pin(2, 1'b0);
    idle(2);
    chk_reg(2'd3, 32'h4, "R4 falling edge");
    chk_grp(4'h1, "R9 group 0 line 2");
    wr(2'd3, 32'h4);

    // R4 both edges line 5
    set_pin(5, 1'b0);
    idle(2);
    chk_reg(2'd3, 32'h20, "R4 both falling");
    chk_grp(4'h2, "R9 group 1");
    wr(2'd3, 32'h20);
    set_pin(5, 1'b1);
    idle(2);
    chk_reg(2'd3, 32'h20, "R4 both rising");
    wr(2'd3, 32'h20);

    // R7 / R8 high level line 6
    set_pin(6, 1'b1);
    idle(2);
    chk_reg(2'd3, 32'h40, "R7 high level sets");
    wr(2'd3, 32'h40);
    chk_reg(2'd3, 32'h40, "R8 clear with event stays set");
    set_pin(6, 1'b0);
    idle(2);
    chk_reg(2'd3, 32'h40, "R7 sticky after release");
    wr(2'd3, 32'h40);
    chk_reg(2'd3, 32'h0, "R7 clear after release");

    // R5 masked line 16 still records
    wr(2'd2, 32'h00010000);
    set_pin(16, 1'b0);
    idle(2);
    chk_reg(2'd3, 32'h00010000, "R5 masked line pending");
    chk_grp(4'h0, "R5 masked line quiet");
    wr(2'd2, 32'h0);
    chk_grp(4'h4, "R9 group 2 after unmask");
    wr(2'd3, 32'h00010000);

    // R4 low level line 9 and rising line 26
    set_pin(9, 1'b0);
    set_pin(26, 1'b0);
    idle(3);
    set_pin(26, 1'b1);
    idle(2);
    chk_reg(2'd3, 32'h04000200, "R4 low level and rise");
    chk_grp(4'hA, "R9 groups 1 and 3");

    @(negedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule